// File: doc/BRIEF.md
# Two-Bit-Per-Cycle Distributed-Arithmetic Inner Product

The block forms the inner product of four 16-bit two's-complement operands with four fixed coefficients and uses no multiplier. The coefficients are elaboration parameters. From them the block computes a 16-entry table, which holds the sum of every subset of the four coefficients. Two copies of this table are addressed in each cycle. One is addressed by the even bit-plane of the four operands and the other by the odd bit-plane. The two table words and the running accumulator are reduced by a carry-save row and then resolved by one 20-bit carry-propagate adder. The accumulator is shifted right by two places on every step, so a whole operand is consumed in eight cycles, least significant pair first.

The bit-plane that carries the operand sign is subtracted rather than added. A start strobe that arrives with the first pair opens a pass. A one-cycle strobe then marks the new result. The next pass may start in the cycle straight after the last pair of the previous one, so a stream of passes runs with no idle cycles.

Top module: `da2_mac`

## Requirements
- R1: After reset, and after any reset during a pass, `done` is 0 and `result` is 0.
- R2: In the k-th cycle of a pass (k = 0..7), bit j of `plane_even` carries bit 2k of operand Xj and bit j of `plane_odd` carries bit 2k+1 of Xj. Pair 0 is presented together with `start`, and pairs 1..7 follow in the next seven consecutive cycles.
- R3: `result` equals floor((C0·X0 + C1·X1 + C2·X2 + C3·X3) / 2^14) as a 20-bit two's-complement value, where Cj is the coefficient in bits [16j+15:16j] of `COEFS`.
- R4: Bit 15 of every operand has weight −2^15, so operands of −32768 and 32767 give the exact floor value of R3.
- R5: `done` is high for exactly one cycle. It rises at the clock edge that samples pair 7, and `result` changes at that same edge.
- R6: Between completions, `result` holds its value and `done` stays low. Plane inputs presented while no pass is running have no effect.
- R7: A `start` in the cycle right after pair 7 begins a new pass with no gap, and each pass of the stream produces its own correct result.
- R8: A `start` during a running pass abandons that pass. The next `done` carries the result of the new operands only, eight cycles after the new `start`.
- R9: Any coefficient set with |Cj| ≤ 8191 yields the R3 result with no overflow in the 20-bit datapath.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Opens a pass; accompanies pair 0 |
| plane_even | input | 4 | Bit 2k of each operand, bit j for operand j |
| plane_odd | input | 4 | Bit 2k+1 of each operand, bit j for operand j |
| done | output | 1 | One-cycle strobe marking a new result |
| result | output | 20 | Scaled inner product, two's complement |

## Verification
The bench builds two copies of the block and feeds both the same operand stream. The first copy uses the default coefficients (5793, −3135, 7568, −1598). The second sets every coefficient to 8191, which gives the largest table word the format allows. With all operands at 32767, the second copy pushes the carry-save row and the 20-bit adder to within a few units of their range. With all operands at −32768, it puts the largest possible value on the negated sign plane.

// File: rtl/da2_pkg.sv
package da2_pkg;
    // Number of operands sharing one table address.
    localparam int DA_TERMS = 4;
    // Entries of one subset-sum table.
    localparam int DA_DEPTH = 1 << DA_TERMS;
    // Shift applied to the even table word before accumulation.
    localparam int DA_PRESHIFT = 2;
endpackage

// File: rtl/da_coef_rom.sv
module da_coef_rom #(
    parameter int TERMS = 4,
    parameter int CW    = 16,
    parameter logic [TERMS*CW-1:0] COEFS = '0
) (
    input  logic [TERMS-1:0]       addr,
    output logic signed [CW-1:0]   word
);
    localparam int DEPTH = 1 << TERMS;
    localparam int SW    = CW + 2;

    function automatic logic signed [CW-1:0] subset_sum(input int unsigned a);
        logic signed [SW-1:0] s;
        s = '0;
        for (int j = 0; j < TERMS; j++) begin
            if (((a >> j) & 32'd1) != 32'd0) begin
                s = s + SW'($signed(COEFS[j*CW +: CW]));
            end
        end
        return s[CW-1:0];
    endfunction

    logic signed [CW-1:0] tbl [DEPTH];

    for (genvar a = 0; a < DEPTH; a++) begin : g_word
        assign tbl[a] = subset_sum(a);
    end

    assign word = tbl[addr];
endmodule

// File: rtl/da_csa_row.sv
module da_csa_row #(
    parameter int W = 20
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] c,
    output logic [W-1:0] sum,
    output logic [W-1:0] carry
);
    for (genvar i = 0; i < W; i++) begin : g_fa
        assign sum[i]   = a[i] ^ b[i] ^ c[i];
        assign carry[i] = (a[i] & b[i]) | (a[i] & c[i]) | (b[i] & c[i]);
    end

    always_comb begin
        // R3
        csa_sum_chk: assert (W'(sum + (carry << 1)) == W'(a + b + c));
    end
endmodule

// File: rtl/da2_mac.sv
module da2_mac
    import da2_pkg::*;
#(
    parameter int IN_W  = 16,
    parameter int CW    = 16,
    parameter int ACC_W = 20,
    parameter logic [DA_TERMS*CW-1:0] COEFS =
        {16'(-1598), 16'(7568), 16'(-3135), 16'(5793)}
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [DA_TERMS-1:0]  plane_even,
    input  logic [DA_TERMS-1:0]  plane_odd,
    output logic                 done,
    output logic [ACC_W-1:0]     result
);
    localparam int PAIRS  = IN_W / 2;
    localparam int STEP_W = $clog2(PAIRS);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(PAIRS - 1);

    typedef struct packed {
        logic                    busy;
        logic [STEP_W-1:0]       step;
        logic signed [ACC_W-1:0] acc;
        logic signed [ACC_W-1:0] res;
        logic                    done;
    } st_t;

    st_t st_d, st_q;

    logic signed [CW-1:0]    word_even, word_odd, odd_sel;
    logic [ACC_W-1:0]        op_acc, op_even, op_odd;
    logic [ACC_W-1:0]        csa_s, csa_c;
    logic signed [ACC_W-1:0] cpa_sum, acc_next;
    logic [STEP_W-1:0]       cur_step;
    logic                    active, last;

    da_coef_rom #(.TERMS(DA_TERMS), .CW(CW), .COEFS(COEFS)) u_rom_even (
        .addr (plane_even),
        .word (word_even)
    );

    da_coef_rom #(.TERMS(DA_TERMS), .CW(CW), .COEFS(COEFS)) u_rom_odd (
        .addr (plane_odd),
        .word (word_odd)
    );

    // Operand preparation: the sign plane is negated as ~w*8 + 7 plus carry-in 1.
    always_comb begin
        active   = start | st_q.busy;
        cur_step = start ? '0 : st_q.step;
        last     = st_q.busy && !start && (st_q.step == LAST_STEP);
        odd_sel  = last ? ~word_odd : word_odd;
        op_acc   = start ? '0 : st_q.acc;
        op_even  = ACC_W'(word_even) <<< DA_PRESHIFT;
        op_odd   = (ACC_W'(odd_sel) <<< (DA_PRESHIFT + 1))
                 | (last ? ACC_W'((1 << (DA_PRESHIFT + 1)) - 1) : '0);
    end

    da_csa_row #(.W(ACC_W)) u_csa (
        .a     (op_acc),
        .b     (op_even),
        .c     (op_odd),
        .sum   (csa_s),
        .carry (csa_c)
    );

    always_comb begin
        cpa_sum  = csa_s + (csa_c << 1) + ACC_W'(last);
        acc_next = cpa_sum >>> 2;

        st_d      = st_q;
        st_d.done = 1'b0;
        if (active) begin
            st_d.acc  = acc_next;
            st_d.step = cur_step + STEP_W'(1);
            st_d.busy = !last;
            if (last) begin
                st_d.res  = acc_next;
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done   = st_q.done;
    assign result = st_q.res;

    // R5
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |=> !st_q.done);

    // R5
    done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |-> $past(st_q.busy && !start && st_q.step == LAST_STEP));

    // R2
    start_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (st_q.busy && st_q.step == STEP_W'(1)));

    // R6
    res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.done |-> $stable(st_q.res));

    // R8
    busy_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && st_q.step != LAST_STEP) |=> st_q.busy);
endmodule

// File: tb/da2_mac_bench.sv
module da2_mac_bench;
    localparam int CLK_P = 10;
    localparam int NV    = 10;
    localparam int SHIFT = 14;

    localparam int CA [4] = '{5793, -3135, 7568, -1598};
    localparam int CB [4] = '{8191, 8191, 8191, 8191};

    localparam logic signed [15:0] VEC [NV][4] = '{
        '{16'sd0,      16'sd0,      16'sd0,      16'sd0},
        '{16'sd1,      16'sd0,      16'sd0,      16'sd0},
        '{16'sd1234,   -16'sd4321,  16'sd777,    16'sd9000},
        '{-16'sd1,     -16'sd1,     -16'sd1,     -16'sd1},
        '{16'sd32767,  16'sd32767,  16'sd32767,  16'sd32767},
        '{-16'sd32768, -16'sd32768, -16'sd32768, -16'sd32768},
        '{16'sd32767,  -16'sd32768, 16'sd32767,  -16'sd32768},
        '{-16'sd20000, 16'sd15001,  -16'sd3,     16'sd31000},
        '{16'sd21845,  -16'sd21846, 16'sd13107,  -16'sd255},
        '{-16'sd32768, 16'sd1,      16'sd32767,  -16'sd2}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [3:0]        plane_even = '0;
    logic [3:0]        plane_odd = '0;
    logic              done_a, done_b;
    logic [19:0]       res_a, res_b;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  all_done = 1'b0;
    logic signed [15:0] cur_x [4];

    always #(CLK_P / 2) clk = ~clk;

    da2_mac u_da2_mac (
        .clk(clk), .rst_n(rst_n), .start(start),
        .plane_even(plane_even), .plane_odd(plane_odd),
        .done(done_a), .result(res_a)
    );

    da2_mac #(.COEFS({16'(CB[3]), 16'(CB[2]), 16'(CB[1]), 16'(CB[0])})) u_ext (
        .clk(clk), .rst_n(rst_n), .start(start),
        .plane_even(plane_even), .plane_odd(plane_odd),
        .done(done_b), .result(res_b)
    );

    function automatic longint expect_a(input int v);
        longint s = 0;
        for (int j = 0; j < 4; j++) s += longint'(CA[j]) * longint'(VEC[v][j]);
        return s >>> SHIFT;
    endfunction

    function automatic longint expect_b(input int v);
        longint s = 0;
        for (int j = 0; j < 4; j++) s += longint'(CB[j]) * longint'(VEC[v][j]);
        return s >>> SHIFT;
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_result(input string req, input int v);
        check({req, " done"}, longint'(done_a), 1);
        check({req, " default coefs"}, longint'($signed(res_a)), expect_a(v));
        check({req, " max coefs"}, longint'($signed(res_b)), expect_b(v));
    endtask

    // R2: pair k of the operands in cur_x onto the plane ports.
    task automatic drive_pair(input int k, input logic st);
        start = st;
        for (int j = 0; j < 4; j++) begin
            plane_even[j] = cur_x[j][2*k];
            plane_odd[j]  = cur_x[j][2*k+1];
        end
    endtask

    task automatic load(input int v);
        for (int j = 0; j < 4; j++) cur_x[j] = VEC[v][j];
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 reset done", longint'(done_a), 0);
        check("R1 reset result", longint'(res_a), 0);

        // R3 R4 R7: the vector table as one gap-free stream of passes
        for (int v = 0; v < NV; v++) begin
            for (int k = 0; k < 8; k++) begin
                @(negedge clk);
                if (k == 0 && v > 0) check_result("R3/R4/R7 stream", v - 1);
                if (k == 1) check("R5 done one cycle", longint'(done_a), 0);
                if (k == 0) load(v);
                drive_pair(k, k == 0);
            end
        end
        @(negedge clk);
        check_result("R3/R4 last", NV - 1);
        start = 1'b0;

        // R6: idle plane activity leaves the result and strobe alone
        for (int i = 0; i < 6; i++) begin
            plane_even = 4'(i * 5 + 3);
            plane_odd  = 4'(15 - i * 2);
            @(negedge clk);
            check("R6 idle done", longint'(done_a), 0);
            check("R6 idle result", longint'($signed(res_a)), expect_a(NV - 1));
        end

        // R8: restart in the middle of a pass
        load(3);
        for (int k = 0; k < 3; k++) begin
            drive_pair(k, k == 0);
            @(negedge clk);
        end
        load(7);
        for (int k = 0; k < 8; k++) begin
            drive_pair(k, k == 0);
            @(negedge clk);
            if (k < 7) check("R8 no early done", longint'(done_a), 0);
        end
        start = 1'b0;
        check_result("R8 restart", 7);
        @(negedge clk);
        check("R5 strobe drops", longint'(done_a), 0);

        // R1: reset during a pass
        load(2);
        for (int k = 0; k < 4; k++) begin
            drive_pair(k, k == 0);
            @(negedge clk);
        end
        start = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check("R1 mid-pass reset done", longint'(done_a), 0);
            check("R1 mid-pass reset result", longint'(res_a), 0);
        end

        // R9 R3: a clean pass after reset with the extreme operand set
        load(5);
        for (int k = 0; k < 8; k++) begin
            drive_pair(k, k == 0);
            @(negedge clk);
        end
        start = 1'b0;
        check_result("R9 after reset", 5);

        all_done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_P * 20000);
        if (!all_done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule